// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps the program order of instructions that a speculative out-of-order core runs. Each instruction gets an entry when it issues. The index of that entry is its tag. Reservation stations wait on that tag, and functional units broadcast results on a common data bus (CDB) carrying the same tag. The buffer captures each result in the tagged entry. Because the register file is written only at retirement, the buffer also returns a completed result by tag to instructions that are about to issue.

Entries retire strictly from the head, and only once their result is present. A register-writing or store entry is presented on the commit stream, which names the destination register or store address and carries the value. Two cases at the head discard all speculative state in one cycle and reset the buffer to empty. The first is a branch whose result was flagged mispredicted; the restart address is the value that branch carried. The second is an entry that recorded an exception; the buffer then reports the faulting PC.

Issue and commit use valid/ready handshakes. An issue is accepted in a cycle where `iss_valid` and `iss_ready` are both high. `iss_ready` depends only on internal state. It is low when all entries are in use or when a flush is happening. The returned tag must be taken in the same cycle. The commit sink may hold `cm_ready` low for any number of cycles. While it does, the head entry is presented unchanged. The CDB, the lookup and the flush and exception outputs are plain signals with no handshake.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty: `iss_ready`=1, `iss_tag`=0, and `cm_valid`, `flush_o`, `exc_o` and `lk_hit` are all 0.
- R2: Accepted issues receive tags 0,1,2,... in order, wrapping modulo DEPTH (default 8). `iss_tag` always shows the tag the next issue will receive.
- R3: Once DEPTH entries are in use, `iss_ready` is 0. An issue offered while `iss_ready` is 0 is ignored: it allocates no entry and does not change the next tag.
- R4: A CDB write to an allocated entry stores its value, exception flag and mispredict flag. From the next cycle, a lookup of that tag gives `lk_hit`=1 and the value. A lookup of an unallocated or incomplete tag gives `lk_hit`=0.
- R5: `cm_valid` is 1 only when the head entry has its result and carries neither an exception nor a mispredict. Entries commit in issue order even when their results arrive out of order. The commit stream carries the head entry's value.
- R6: While `cm_valid`=1 and `cm_ready`=0, the head is held: `cm_valid`, `cm_kind`, `cm_dest` and `cm_value` stay unchanged in the next cycle.
- R7: When a completed head entry has its mispredict flag set, `flush_o`=1 in that cycle and `flush_pc` is that entry's result value. In the next cycle the buffer is empty, and the next tag is 0.
- R8: When a completed head entry has its exception flag set, `exc_o`=1 and `flush_o`=1 in that cycle, `exc_pc` and `flush_pc` equal that entry's issue PC, and `cm_valid`=0. The exception check takes precedence over the mispredict check.
- R9: An issue and a commit in the same cycle leave the occupancy unchanged.
- R10: Kind codes are 2'b00 for a register write, 2'b01 for a store (dest is the address) and 2'b10 for a branch. `cm_kind` and `cm_dest` repeat the values given at issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | Free entry available and no flush |
| iss_kind | input | 2 | Instruction kind code |
| iss_dest | input | AW (32) | Destination register number or store address |
| iss_pc | input | PW (32) | PC of the issuing instruction |
| iss_tag | output | TW (3) | Tag assigned to the next accepted issue |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | TW (3) | Entry the result belongs to |
| cdb_value | input | DW (32) | Result value, or restart address for a branch |
| cdb_exc | input | 1 | Result raised an exception |
| cdb_mispred | input | 1 | Branch was mispredicted |
| lk_tag | input | TW (3) | Operand lookup tag |
| lk_hit | output | 1 | Looked-up entry holds a result |
| lk_value | output | DW (32) | Looked-up result value |
| cm_valid | output | 1 | Head entry ready to commit |
| cm_ready | input | 1 | Commit sink accepts |
| cm_kind | output | 2 | Kind of the committing entry |
| cm_dest | output | AW (32) | Register number or store address |
| cm_value | output | DW (32) | Value to write |
| flush_o | output | 1 | Speculative state discarded this cycle |
| flush_pc | output | PW (32) | Fetch restart address |
| exc_o | output | 1 | Exception taken at the head |
| exc_pc | output | PW (32) | PC of the faulting instruction |

## Verification
Directed sequences come first. One fills the buffer and then completes its entries out of order while the commit sink stalls; this separates in-order retirement from retirement in completion order, and also covers back-pressure. A short branch sequence flags a mispredict and checks that retirement stops there. A store sequence flags an exception on a store. A same-cycle issue-and-commit sequence separates a count that stays flat from one that drifts. A long seeded random run then mixes issue pressure, out-of-order CDB writes, rare faults and a random commit sink. A bench model of the queue checks every tag, ready, lookup, commit, flush and exception output in every cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_BRANCH = 2'b10
  } rob_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             retire,
  input  logic             flush,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (retire) head <= bump(head);
      if (alloc)  tail <= bump(tail);
      count <= count + CNT_W'(alloc) - CNT_W'(retire);
    end
  end

  assign full = (count == CNT_W'(DEPTH));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R9
  same_cycle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && retire && !flush) |=> (count == $past(count)));
  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && head == '0 && tail == '0));
endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int PW = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             alloc,
  input  logic [PTR_W-1:0] tail,
  input  rob_kind_e        a_kind,
  input  logic [AW-1:0]    a_dest,
  input  logic [PW-1:0]    a_pc,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_tag,
  input  logic [DW-1:0]    wr_value,
  input  logic             wr_exc,
  input  logic             wr_mis,
  input  logic             retire,
  input  logic [PTR_W-1:0] head,
  input  logic [PTR_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [DW-1:0]    lk_value,
  output logic             h_ready,
  output logic             h_exc,
  output logic             h_mis,
  output rob_kind_e        h_kind,
  output logic [AW-1:0]    h_dest,
  output logic [DW-1:0]    h_value,
  output logic [PW-1:0]    h_pc
);
  logic [DEPTH-1:0] used_q, done_q, exc_q, mis_q;
  rob_kind_e        kind_q [DEPTH];
  logic [AW-1:0]    dest_q [DEPTH];
  logic [DW-1:0]    val_q  [DEPTH];
  logic [PW-1:0]    pc_q   [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        used_q[i] <= 1'b0;
        done_q[i] <= 1'b0;
        exc_q[i]  <= 1'b0;
        mis_q[i]  <= 1'b0;
      end else if (alloc && tail == PTR_W'(i)) begin
        used_q[i] <= 1'b1;
        done_q[i] <= 1'b0;
        exc_q[i]  <= 1'b0;
        mis_q[i]  <= 1'b0;
        kind_q[i] <= a_kind;
        dest_q[i] <= a_dest;
        pc_q[i]   <= a_pc;
      end else if (retire && head == PTR_W'(i)) begin
        used_q[i] <= 1'b0;
        done_q[i] <= 1'b0;
      end else if (wr_en && wr_tag == PTR_W'(i) && used_q[i]) begin
        done_q[i] <= 1'b1;
        val_q[i]  <= wr_value;
        exc_q[i]  <= wr_exc;
        mis_q[i]  <= wr_mis;
      end
    end
  end

  assign lk_hit   = used_q[lk_tag] && done_q[lk_tag];
  assign lk_value = val_q[lk_tag];

  assign h_ready = used_q[head] && done_q[head];
  assign h_exc   = exc_q[head];
  assign h_mis   = mis_q[head];
  assign h_kind  = kind_q[head];
  assign h_dest  = dest_q[head];
  assign h_value = val_q[head];
  assign h_pc    = pc_q[head];

  // R4
  cdb_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && used_q[wr_tag] && !flush && !(retire && head == wr_tag) &&
     !(alloc && tail == wr_tag))
    |=> (done_q[$past(wr_tag)] && val_q[$past(wr_tag)] == $past(wr_value)));
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_ready,
  input  logic          h_exc,
  input  logic          h_mis,
  input  rob_kind_e     h_kind,
  input  logic [AW-1:0] h_dest,
  input  logic [DW-1:0] h_value,
  input  logic [PW-1:0] h_pc,
  input  logic          cm_ready,
  output logic          cm_valid,
  output logic [1:0]    cm_kind,
  output logic [AW-1:0] cm_dest,
  output logic [DW-1:0] cm_value,
  output logic          retire,
  output logic          flush,
  output logic [PW-1:0] flush_pc,
  output logic          exc_take,
  output logic [PW-1:0] exc_pc
);
  logic mis_take;

  assign exc_take = h_ready && h_exc;
  assign mis_take = h_ready && !h_exc && h_mis;
  assign flush    = exc_take || mis_take;
  assign flush_pc = exc_take ? h_pc : PW'(h_value);
  assign exc_pc   = h_pc;

  assign cm_valid = h_ready && !flush;
  assign cm_kind  = h_kind;
  assign cm_dest  = h_dest;
  assign cm_value = h_value;
  assign retire   = cm_valid && cm_ready;

  // R8
  exc_flushes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> (flush && !cm_valid));
  // R6
  commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !cm_ready) |=>
      (cm_valid && $stable(cm_value) && $stable(cm_dest) && $stable(cm_kind)));
  // R5
  commit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cm_valid && flush));
endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int PW = 32,
  localparam int TW = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  output logic          iss_ready,
  input  logic [1:0]    iss_kind,
  input  logic [AW-1:0] iss_dest,
  input  logic [PW-1:0] iss_pc,
  output logic [TW-1:0] iss_tag,
  input  logic          cdb_valid,
  input  logic [TW-1:0] cdb_tag,
  input  logic [DW-1:0] cdb_value,
  input  logic          cdb_exc,
  input  logic          cdb_mispred,
  input  logic [TW-1:0] lk_tag,
  output logic          lk_hit,
  output logic [DW-1:0] lk_value,
  output logic          cm_valid,
  input  logic          cm_ready,
  output logic [1:0]    cm_kind,
  output logic [AW-1:0] cm_dest,
  output logic [DW-1:0] cm_value,
  output logic          flush_o,
  output logic [PW-1:0] flush_pc,
  output logic          exc_o,
  output logic [PW-1:0] exc_pc
);
  logic [TW-1:0]    head, tail;
  logic [CNT_W-1:0] count;
  logic             full, alloc, retire, flush;
  logic             h_ready, h_exc, h_mis;
  rob_kind_e        h_kind;
  logic [AW-1:0]    h_dest;
  logic [DW-1:0]    h_value;
  logic [PW-1:0]    h_pc;

  assign iss_ready = !full && !flush;
  assign alloc     = iss_valid && iss_ready;
  assign iss_tag   = tail;
  assign flush_o   = flush;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .retire(retire), .flush(flush),
    .head(head), .tail(tail), .count(count), .full(full)
  );

  rob_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .PW(PW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc(alloc), .tail(tail), .a_kind(rob_kind_e'(iss_kind)),
    .a_dest(iss_dest), .a_pc(iss_pc),
    .wr_en(cdb_valid), .wr_tag(cdb_tag), .wr_value(cdb_value),
    .wr_exc(cdb_exc), .wr_mis(cdb_mispred),
    .retire(retire), .head(head),
    .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_value(lk_value),
    .h_ready(h_ready), .h_exc(h_exc), .h_mis(h_mis), .h_kind(h_kind),
    .h_dest(h_dest), .h_value(h_value), .h_pc(h_pc)
  );

  rob_retire #(.DW(DW), .AW(AW), .PW(PW)) u_retire (
    .clk(clk), .rst_n(rst_n),
    .h_ready(h_ready), .h_exc(h_exc), .h_mis(h_mis), .h_kind(h_kind),
    .h_dest(h_dest), .h_value(h_value), .h_pc(h_pc),
    .cm_ready(cm_ready), .cm_valid(cm_valid), .cm_kind(cm_kind),
    .cm_dest(cm_dest), .cm_value(cm_value), .retire(retire),
    .flush(flush), .flush_pc(flush_pc), .exc_take(exc_o), .exc_pc(exc_pc)
  );

  // R3
  full_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !iss_ready);
  // R2
  tag_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !flush && tail != TW'(DEPTH - 1)) |=> (tail == $past(tail) + 1'b1));
endmodule

// File: tb/tb_reorder_buf.sv
module tb_reorder_buf;
  logic        clk = 0, rst_n = 0;
  logic        iss_valid = 0, cdb_valid = 0, cdb_exc = 0, cdb_mispred = 0, cm_ready = 0;
  logic [1:0]  iss_kind = 0;
  logic [31:0] iss_dest = 0, iss_pc = 0, cdb_value = 0;
  logic [2:0]  cdb_tag = 0, lk_tag = 0;
  logic        iss_ready, lk_hit, cm_valid, flush_o, exc_o;
  logic [2:0]  iss_tag;
  logic [1:0]  cm_kind;
  logic [31:0] lk_value, cm_dest, cm_value, flush_pc, exc_pc;

  always #5 clk = ~clk;

  reorder_buf dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_kind(iss_kind), .iss_dest(iss_dest), .iss_pc(iss_pc), .iss_tag(iss_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .cdb_exc(cdb_exc), .cdb_mispred(cdb_mispred),
    .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_value(lk_value),
    .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_kind(cm_kind),
    .cm_dest(cm_dest), .cm_value(cm_value), .flush_o(flush_o),
    .flush_pc(flush_pc), .exc_o(exc_o), .exc_pc(exc_pc)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // bench model of the queue
  bit          m_v[8], m_d[8], m_e[8], m_m[8];
  logic [1:0]  m_k[8];
  logic [31:0] m_dst[8], m_val[8], m_pc[8];
  int          mh = 0, mt = 0, mc = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit head_done();
    return m_v[mh] && m_d[mh];
  endfunction

  task automatic step(input bit iv, input logic [1:0] k, input logic [31:0] d,
                      input logic [31:0] pc, input bit cv, input int ct,
                      input logic [31:0] cval, input bit ce, input bit cmis,
                      input bit crdy, input int lt);
    bit hd, e_exc, e_fl, e_cv, ret, alc;
    @(negedge clk);
    iss_valid = iv; iss_kind = k; iss_dest = d; iss_pc = pc;
    cdb_valid = cv; cdb_tag = 3'(ct); cdb_value = cval; cdb_exc = ce; cdb_mispred = cmis;
    cm_ready = crdy; lk_tag = 3'(lt);
    #1;
    hd    = head_done();
    e_exc = hd && m_e[mh];
    e_fl  = hd && (m_e[mh] || m_m[mh]);
    e_cv  = hd && !e_fl;
    chk("R3 iss_ready", 32'(iss_ready), 32'(mc < 8 && !e_fl));
    chk("R2/R9 iss_tag", 32'(iss_tag), 32'(mt));
    chk("R5 cm_valid", 32'(cm_valid), 32'(e_cv));
    if (e_cv) begin
      chk("R10 cm_kind", 32'(cm_kind), 32'(m_k[mh]));
      chk("R10 cm_dest", cm_dest, m_dst[mh]);
      chk("R5/R6 cm_value", cm_value, m_val[mh]);
    end
    chk("R7 flush_o", 32'(flush_o), 32'(e_fl));
    chk("R8 exc_o", 32'(exc_o), 32'(e_exc));
    if (e_fl) chk("R7/R8 flush_pc", flush_pc, e_exc ? m_pc[mh] : m_val[mh]);
    if (e_exc) chk("R8 exc_pc", exc_pc, m_pc[mh]);
    chk("R4 lk_hit", 32'(lk_hit), 32'(m_v[lt] && m_d[lt]));
    if (m_v[lt] && m_d[lt]) chk("R4 lk_value", lk_value, m_val[lt]);
    // model update for the coming edge
    if (e_fl) begin
      for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_d[i] = 0; end
      mh = 0; mt = 0; mc = 0;
    end else begin
      ret = e_cv && crdy;
      alc = iv && mc < 8;
      if (cv && m_v[ct] && !m_d[ct]) begin
        m_d[ct] = 1; m_val[ct] = cval; m_e[ct] = ce; m_m[ct] = cmis;
      end
      if (ret) begin m_v[mh] = 0; m_d[mh] = 0; mh = (mh + 1) % 8; end
      if (alc) begin
        m_v[mt] = 1; m_d[mt] = 0; m_e[mt] = 0; m_m[mt] = 0;
        m_k[mt] = k; m_dst[mt] = d; m_pc[mt] = pc; mt = (mt + 1) % 8;
      end
      mc = mc + int'(alc) - int'(ret);
    end
  endtask

  task automatic iss(input logic [1:0] k, input logic [31:0] d, input logic [31:0] pc);
    step(1, k, d, pc, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic cdb(input int t, input logic [31:0] v, input bit e, input bit m, input bit rdy);
    step(0, 0, 0, 0, 1, t, v, e, m, rdy, t);
  endtask

  task automatic idle(input bit rdy, input int lt);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, rdy, lt);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 iss_ready", 32'(iss_ready), 1);
    chk("R1 iss_tag", 32'(iss_tag), 0);
    chk("R1 cm_valid", 32'(cm_valid), 0);
    chk("R1 flush_o", 32'(flush_o), 0);
    chk("R1 exc_o", 32'(exc_o), 0);
    chk("R1 lk_hit", 32'(lk_hit), 0);
    rst_n = 1;

    // R3: fill, then offer one more issue while full
    for (int i = 0; i < 8; i++) iss(2'(i % 2), 32'(100 + i), 32'(32'h400 + 4 * i));
    iss(0, 32'hdead, 32'hbeef);
    // R5/R6: complete out of order, sink stalled
    cdb(5, 32'h55, 0, 0, 0);
    cdb(2, 32'h22, 0, 0, 0);
    idle(0, 5);
    cdb(0, 32'h11, 0, 0, 0);
    idle(0, 0); idle(0, 0); idle(0, 2);
    for (int i = 1; i < 8; i++) if (i != 2 && i != 5) cdb(i, 32'(i * 3), 0, 0, 0);
    for (int i = 0; i < 10; i++) idle(1, i % 8);

    // R7: mispredicted branch in the middle
    iss(0, 1, 32'h1000);
    iss(2, 0, 32'h1004);
    iss(0, 2, 32'h1008);
    cdb(2, 32'h77, 0, 0, 0);
    cdb(1, 32'h1234, 0, 1, 0);
    cdb(0, 32'h99, 0, 0, 0);
    for (int i = 0; i < 4; i++) idle(1, 2);

    // R8: exception on a store, and exception beats mispredict
    iss(1, 32'h8000, 32'habc);
    iss(2, 0, 32'habc4);
    cdb(0, 32'h5, 1, 0, 1);
    idle(1, 0); idle(1, 0);
    iss(2, 0, 32'hc00);
    cdb(0, 32'h600, 1, 1, 1);
    idle(1, 0);

    // R9: issue and commit in one cycle
    iss(0, 3, 32'h2000);
    iss(0, 4, 32'h2004);
    cdb(0, 32'hab, 0, 0, 0);
    step(1, 0, 5, 32'h2008, 0, 0, 0, 0, 0, 1, 0);
    idle(0, 1);
    for (int i = 0; i < 3; i++) cdb((1 + i) % 8, 32'(i), 0, 0, 1);
    for (int i = 0; i < 4; i++) idle(1, 0);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      bit iv, cv, ce, cm, rdy;
      logic [1:0] k;
      int ct, st;
      iv = ($urandom % 3) != 0;
      k  = 2'($urandom % 3);
      cv = 0; ct = 0; ce = 0; cm = 0;
      st = int'($urandom % 8);
      for (int j = 0; j < 8; j++) begin
        int t;
        t = (st + j) % 8;
        if (!cv && m_v[t] && !m_d[t] && ($urandom % 4) != 0) begin cv = 1; ct = t; end
      end
      if (cv) begin
        ce = ($urandom % 50) == 0;
        cm = (m_k[ct] == 2'b10) && (($urandom % 5) == 0);
      end
      rdy = ($urandom % 4) != 0;
      step(iv, k, $urandom, $urandom, cv, ct, $urandom, ce, cm, rdy, int'($urandom % 8));
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule